// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block watches up to sixteen external input lines that arrive with no relation to the system clock. It raises one interrupt request when any of them has held an active level for a programmed length of time. Every line goes through a two-stage synchroniser. Each channel then has its own active level (high or low), its own debounce time counted in millisecond ticks, and its own enable. A millisecond tick comes from a free-running divider of the system clock. Software reads and writes all of this through a simple word-addressed register bus.

A channel does not flag on its own. Software first arms it by writing a 1 to the channel's bit in the trigger register. From then on, the channel must see its synchronised input at the selected level for the whole debounce time. Only then does it set its raw status bit and disarm itself. The raw bit stays set until software writes a 1 to the matching bit of the clear register. After that, software must arm the channel again before it can flag again. Software can emulate edge detection by flipping the polarity between arming steps; the block itself detects levels only.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The level register (word offset 0x00) returns synchronised input n in bit n only while data-mask bit n (offset 0x04) is set. Otherwise it returns 0 for that bit. An input change appears in the read value on the second rising clock edge after it is sampled.
- R3: Polarity bit n (offset 0x14) set to 1 makes channel n active while its input is high. Set to 0, the channel is active while its input is low.
- R4: A write of 1 to bit n of the trigger register (offset 0x28) arms channel n and restarts its count. An armed channel sets raw status bit n once its synchronised input has been active for D millisecond ticks without a break, where D is bits [11:0] of its control word. A break resets the count to 0. With D = 0, the bit sets on the first active cycle.
- R5: Once raw status bit n is set, it stays set until cleared. Once the channel has flagged, it stays disarmed, so it cannot flag again until a new trigger write.
- R6: The masked status register (offset 0x20) reads the raw status (offset 0x1C) ANDed with the enable register (offset 0x18). `irq` is high exactly when any masked status bit is set.
- R7: A write to the clear register (offset 0x24) clears the raw status bits written as 1 and leaves the bits written as 0 unchanged.
- R8: The control word of channel n sits at offset 0x40 + 4n and reads back all 32 bits as written. Only bits [11:0] set the debounce time.
- R9: Writes to the raw status and masked status registers are ignored. The trigger and clear registers read as 0.
- R10: A read of any unmapped offset returns 0, and `bus_rdata` is 0 unless a read is in progress (`bus_sel` high, `bus_we` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ext_in | input | NCH | Asynchronous external input lines |
| irq | output | 1 | Interrupt request, high while any masked status bit is set |

## Verification
The assertions assume that the bus inputs hold steady between rising edges. A write is taken as complete in the single cycle in which `bus_sel` and `bus_we` are both high. The external lines may change at any time, because only their synchronised copies reach the logic. The bench drives every input on the falling edge and keeps each write to one cycle. It toggles the inputs only between edges, both during and outside debounce windows, so that breaks in a count, zero-length debounce and re-arming after a clear all occur under those same conditions.

// File: rtl/lic_pkg.sv
package lic_pkg;
  // Word offsets (byte address / 4) of the register map
  localparam int A_LEVEL  = 'h00;
  localparam int A_DMASK  = 'h01;
  localparam int A_POL    = 'h05;
  localparam int A_EN     = 'h06;
  localparam int A_RAW    = 'h07;
  localparam int A_MASKED = 'h08;
  localparam int A_CLR    = 'h09;
  localparam int A_TRIG   = 'h0A;
  localparam int A_CTRL0  = 'h10;

  localparam int DBNC_W   = 12;
  localparam int DATA_W   = 32;

  // debounce reached: the active run has lasted the programmed tick count
  function automatic logic dbnc_reached(input logic [DBNC_W-1:0] run,
                                        input logic [DBNC_W-1:0] limit);
    return run >= limit;
  endfunction

  // channel active when its level equals the selected polarity
  function automatic logic chan_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // debounce field of a control word
  function automatic logic [DBNC_W-1:0] dbnc_field(input logic [DATA_W-1:0] w);
    return w[DBNC_W-1:0];
  endfunction
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/lic_tick.sv
module lic_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/lic_chan.sv
module lic_chan
  import lic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              level,
  input  logic              pol,
  input  logic [DBNC_W-1:0] limit,
  input  logic              arm_req,
  output logic              armed,
  output logic              hit
);
  logic              arm_q;
  logic [DBNC_W-1:0] run_q;
  logic              active;

  assign active = chan_active(level, pol);
  assign hit    = arm_q && active && dbnc_reached(run_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      run_q <= '0;
    end else if (arm_req) begin
      arm_q <= 1'b1;
      run_q <= '0;
    end else if (arm_q) begin
      if (!active)  run_q <= '0;
      else if (hit) arm_q <= 1'b0;
      else if (tick) run_q <= run_q + 1'b1;
    end
  end

  assign armed = arm_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int MS_DIV = 50000,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ext_in,
  output logic              irq
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0]     word;
  logic              wr_go;
  logic              rd_go;
  logic              tick;
  logic [NCH-1:0]    lvl_s;
  logic [NCH-1:0]    dmask_q, pol_q, en_q, raw_q;
  logic [NCH-1:0]    arm_q, set_evt, clr_evt, trig_evt;
  logic [DATA_W-1:0] ctrl_q [NCH];
  logic [DATA_W-1:0] rd_mux;

  assign word  = bus_addr[ADDR_W-1:2];
  assign wr_go = bus_sel && bus_we;
  assign rd_go = bus_sel && !bus_we;

  lic_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .sync_out(lvl_s)
  );

  lic_tick #(.DIV(MS_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign trig_evt = (wr_go && int'(word) == A_TRIG) ? bus_wdata[NCH-1:0] : '0;
  assign clr_evt  = (wr_go && int'(word) == A_CLR)  ? bus_wdata[NCH-1:0] : '0;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic ctrl_we;
      assign ctrl_we = wr_go && (int'(word) == A_CTRL0 + i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q[i] <= '0;
        else if (ctrl_we) ctrl_q[i] <= bus_wdata;
      end

      lic_chan u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .level(lvl_s[i]), .pol(pol_q[i]),
        .limit(dbnc_field(ctrl_q[i])),
        .arm_req(trig_evt[i]),
        .armed(arm_q[i]), .hit(set_evt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (wr_go) begin
      if (int'(word) == A_DMASK) dmask_q <= bus_wdata[NCH-1:0];
      if (int'(word) == A_POL)   pol_q   <= bus_wdata[NCH-1:0];
      if (int'(word) == A_EN)    en_q    <= bus_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_evt) | set_evt;
  end

  always_comb begin
    rd_mux = '0;
    case (int'(word))
      A_LEVEL:  rd_mux[NCH-1:0] = lvl_s & dmask_q;
      A_DMASK:  rd_mux[NCH-1:0] = dmask_q;
      A_POL:    rd_mux[NCH-1:0] = pol_q;
      A_EN:     rd_mux[NCH-1:0] = en_q;
      A_RAW:    rd_mux[NCH-1:0] = raw_q;
      A_MASKED: rd_mux[NCH-1:0] = raw_q & en_q;
      default: begin
        for (int k = 0; k < NCH; k++)
          if (int'(word) == A_CTRL0 + k) rd_mux = ctrl_q[k];
      end
    endcase
  end

  assign bus_rdata = rd_go ? rd_mux : '0;
  assign irq       = |(raw_q & en_q);
endmodule

// File: rtl/lic_check.sv
module lic_check
  import lic_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int MS_DIV = 50000,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic [NCH-1:0]    arm_q,
  input logic [NCH-1:0]    raw_q,
  input logic [NCH-1:0]    set_evt,
  input logic [NCH-1:0]    clr_evt,
  input logic [NCH-1:0]    trig_evt,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    dmask_q
);
  // R4: a status bit can only appear on a channel that was armed
  assert_set_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0));

  // R5: a channel that flagged is disarmed unless re-triggered at once
  assert_disarm_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((arm_q & $past(set_evt) & ~$past(trig_evt)) == '0));

  // R5: raw bits only drop through a clear write
  assert_raw_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~raw_q & $past(raw_q) & ~$past(clr_evt)) == '0));

  // R6: no interrupt while every enable is off
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R7: bits written to the clear register are gone next cycle unless set again
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt != '0) |=> ((raw_q & $past(clr_evt) & ~$past(set_evt)) == '0));

  // R2: level read is zero while the data mask is empty
  assert_masked_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[ADDR_W-1:2] == '0 && dmask_q == '0)
      |-> (bus_rdata == '0));

  // R10: idle bus drives zero
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));

  generate
    if (MS_DIV > 1) begin : g_tick_chk
      // R4: millisecond ticks are single-cycle pulses
      assert_tick_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind lvl_irq_ctrl lic_check #(.NCH(NCH), .MS_DIV(MS_DIV), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  localparam int NCH = 16;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ext_in = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  lvl_irq_ctrl #(.NCH(NCH), .MS_DIV(DIV), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .irq(irq)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int          m_div;
  logic [15:0] m_hist [2];
  logic [15:0] m_mask, m_pol, m_en, m_raw, m_arm;
  int          m_run [16];
  logic [31:0] m_ctrl [16];

  function automatic logic [31:0] m_read(logic s, logic w, logic [7:0] a);
    logic [31:0] v = 0;
    int idx = int'(a) / 4;
    if (!s || w) return 0;
    if (idx == 0)       v = {16'h0, m_hist[1] & m_mask};
    else if (idx == 1)  v = {16'h0, m_mask};
    else if (idx == 5)  v = {16'h0, m_pol};
    else if (idx == 6)  v = {16'h0, m_en};
    else if (idx == 7)  v = {16'h0, m_raw};
    else if (idx == 8)  v = {16'h0, m_raw & m_en};
    else if (idx >= 16 && idx < 32) v = m_ctrl[idx-16];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_hist[0] = 0; m_hist[1] = 0;
      m_mask = 0; m_pol = 0; m_en = 0; m_raw = 0; m_arm = 0;
      for (int i = 0; i < 16; i++) begin m_run[i] = 0; m_ctrl[i] = 0; end
    end else begin
      logic tk;
      logic [15:0] setv, clrv, trgv;
      int idx;
      tk = (m_div == DIV - 1);
      idx = int'(bus_addr) / 4;
      trgv = (bus_sel && bus_we && idx == 10) ? bus_wdata[15:0] : 16'h0;
      clrv = (bus_sel && bus_we && idx == 9)  ? bus_wdata[15:0] : 16'h0;
      setv = 0;
      for (int i = 0; i < 16; i++) begin
        logic act;
        act = (m_hist[1][i] == m_pol[i]);
        if (m_arm[i] && act && m_run[i] >= int'(m_ctrl[i] & 32'hFFF)) setv[i] = 1;
        if (trgv[i]) begin m_arm[i] = 1; m_run[i] = 0; end
        else if (m_arm[i]) begin
          if (!act) m_run[i] = 0;
          else if (setv[i]) m_arm[i] = 0;
          else if (tk) m_run[i]++;
        end
      end
      m_raw = (m_raw & ~clrv) | setv;
      if (bus_sel && bus_we) begin
        if (idx == 1) m_mask = bus_wdata[15:0];
        if (idx == 5) m_pol  = bus_wdata[15:0];
        if (idx == 6) m_en   = bus_wdata[15:0];
        if (idx >= 16 && idx < 32) m_ctrl[idx-16] = bus_wdata;
      end
      m_hist[1] = m_hist[0]; m_hist[0] = ext_in;
      m_div = tk ? 0 : m_div + 1;
    end
  end

  // compare every clock, a quarter period after the rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      n_chk++;
      if (irq !== |(m_raw & m_en)) begin
        n_fail++;
        $display("FAIL R6 irq per-cycle: actual %0b expected %0b", irq, |(m_raw & m_en));
      end
      n_chk++;
      if (bus_rdata !== m_read(bus_sel, bus_we, bus_addr)) begin
        n_fail++;
        $display("FAIL R9 rdata per-cycle @%h: actual %h expected %h",
                 bus_addr, bus_rdata, m_read(bus_sel, bus_we, bus_addr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk("R1 irq after reset", {31'h0, irq}, 0);
    foreach (v[k]) ; // no-op to keep loop-free declarations simple
    rd(8'h04, v); chk("R1 mask reset", v, 0);
    rd(8'h14, v); chk("R1 pol reset", v, 0);
    rd(8'h1C, v); chk("R1 raw reset", v, 0);
    rd(8'h4C, v); chk("R1 ctrl3 reset", v, 0);

    // R2: gated level read
    ext_in = 16'hA5C3;
    idle(3);
    rd(8'h00, v); chk("R2 level masked off", v, 0);
    wr(8'h04, 32'h0000_00FF);
    rd(8'h00, v); chk("R2 level low byte", v, 32'h0000_00C3);
    wr(8'h04, 32'h0000_FFFF);
    ext_in = 16'h0000;
    rd(8'h00, v); chk("R2 level before sync", v, 32'h0000_A5C3);
    idle(2);
    rd(8'h00, v); chk("R2 level after sync", v, 0);

    // R8: control word readback
    wr(8'h4C, 32'hDEAD_B003);
    rd(8'h4C, v); chk("R8 ctrl3 readback", v, 32'hDEAD_B003);
    wr(8'h4C, 32'h0000_0003);

    // R3/R4: channel 3 active high, 3 ticks
    wr(8'h14, 32'h0000_0008);
    wr(8'h18, 32'h0000_0008);
    ext_in[3] = 1;
    idle(3);
    wr(8'h28, 32'h0000_0008);
    chk("R4 no irq right after trigger", {31'h0, irq}, 0);
    idle(20);
    chk("R3 high-active channel flags", {31'h0, irq}, 1);
    rd(8'h20, v); chk("R6 masked shows ch3", v, 32'h8);

    // R7: zero bits in clear leave status alone
    wr(8'h24, 32'h0000_0000);
    rd(8'h1C, v); chk("R7 clear with zeros", v, 32'h8);
    // R9: writes to status registers ignored, trigger/clear read 0
    wr(8'h1C, 32'h0000_0000);
    wr(8'h20, 32'h0000_0000);
    rd(8'h1C, v); chk("R9 raw write ignored", v, 32'h8);
    rd(8'h28, v); chk("R9 trigger reads 0", v, 0);
    rd(8'h24, v); chk("R9 clear reads 0", v, 0);

    // R5: clear while still active, no re-flag without trigger
    wr(8'h24, 32'h0000_0008);
    idle(20);
    chk("R5 no re-flag without trigger", {31'h0, irq}, 0);
    wr(8'h28, 32'h0000_0008);
    idle(20);
    chk("R5 re-arm flags again", {31'h0, irq}, 1);
    wr(8'h24, 32'h0000_0008);

    // R3/R4: channel 5 active low, 2 ticks, broken run restarts
    ext_in[5] = 0;
    wr(8'h54, 32'h0000_0002);
    wr(8'h18, 32'h0000_0020);
    idle(3);
    wr(8'h28, 32'h0000_0020);
    idle(3);
    ext_in[5] = 1;
    idle(12);
    chk("R4 break holds off flag", {31'h0, irq}, 0);
    ext_in[5] = 0;
    idle(20);
    chk("R3 low-active channel flags", {31'h0, irq}, 1);

    // R6: raw set but disabled -> no irq
    wr(8'h18, 32'h0000_0000);
    chk("R6 irq off when disabled", {31'h0, irq}, 0);
    rd(8'h1C, v); chk("R6 raw keeps ch5", v, 32'h20);
    rd(8'h20, v); chk("R6 masked empty", v, 0);
    wr(8'h24, 32'h0000_0020);

    // R4: zero debounce on channel 0 (active low, input low)
    wr(8'h18, 32'h0000_0001);
    wr(8'h28, 32'h0000_0001);
    idle(1);
    chk("R4 zero debounce flags at once", {31'h0, irq}, 1);
    wr(8'h24, 32'h0000_0001);
    chk("R7 clear drops irq", {31'h0, irq}, 0);

    // R10: unmapped and idle reads
    rd(8'h08, v); chk("R10 unmapped read", v, 0);
    rd(8'h30, v); chk("R10 unmapped read hi", v, 0);
    idle(1);
    chk("R10 idle rdata", bus_rdata, 0);

    idle(4);
    finish_run();
  end
endmodule